// File: doc/BRIEF.md
# Dual-Read Register File with Same-Cycle Bypass

This block is the general-purpose register storage of a small load/store processor: 32 registers of 32 bits. During decode it yields two source operands at once, with their indices taken straight from fixed fields of the instruction word. During write-back it accepts one destination write per clock.

When write-back updates a register in the same cycle that decode reads it, the read ports return the value being written. This behaves as if the write lands in the first half of the cycle and the read happens in the second half, so the pipeline never has to stall for this overlap.

Index 0 is a constant zero. Writes aimed at it are discarded. A synchronous active-low reset clears every register.

Top module: `regfile_bypass`

## Requirements
- R1: The file holds 32 independent registers of 32 bits each. A value written to any nonzero index reads back unchanged on either port.
- R2: A read of index 0 returns 0 on both ports at all times.
- R3: A write with `wr_en` high is captured at the rising clock edge. From the next cycle onward, reads of that index return the written data.
- R4: When `wr_en` is high, `wr_idx` is nonzero and `wr_idx` equals a port's read index, that port returns `wr_data` in the same cycle, before the edge.
- R5: Source A's index is bits 25:21 of `dec_instr`, and source B's index is bits 20:16. All other instruction bits have no effect on the reads.
- R6: A write to index 0 is discarded. Index 0 still reads 0 afterwards, and no other register changes.
- R7: With `wr_en` low, no register changes, whatever `wr_idx` and `wr_data` hold.
- R8: While `rst_n` is low at a rising edge, every register is cleared to 0.
- R9: A write changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_instr | input | 32 | Instruction in decode; supplies both read indices |
| rd_data_a | output | 32 | Operand for source A (bits 25:21) |
| rd_data_b | output | 32 | Operand for source B (bits 20:16) |
| wr_en | input | 1 | Write-back enable |
| wr_idx | input | 5 | Write-back destination index |
| wr_data | input | 32 | Write-back data |

## Verification
The embedded properties check four things on every cycle:
- each port reads zero at index 0;
- a same-cycle write to the read index is forwarded;
- an enabled write lands in its addressed register by the next cycle;
- every register not addressed by an enabled write holds its value.

Three behaviours are shown only by the bench scenarios, each through values read back at the ports:
- that the index fields sit at bits 25:21 and 20:16, with junk placed in the neighbouring bits;
- that reset clears the whole file, including after it has been written;
- that a discarded write to index 0 leaves all other registers intact.

// File: rtl/regfile_pkg.sv
// Shared sizing for the register file: register count, data width, and
// the positions of the two source-index fields in the instruction word.
package regfile_pkg;
    localparam int unsigned RF_REGS    = 32;
    localparam int unsigned RF_WIDTH   = 32;
    localparam int unsigned RF_IDX_W   = $clog2(RF_REGS);
    localparam int unsigned INSTR_W    = 32;
    localparam int unsigned SRC_A_LSB  = 21;
    localparam int unsigned SRC_B_LSB  = 16;
    localparam int unsigned NUM_RPORTS = 2;
endpackage

// File: rtl/rf_src_decode.sv
// Extracts the two source-register indices from fixed instruction fields.
// Assumes both fields fit inside the instruction word.
module rf_src_decode
    import regfile_pkg::*;
#(
    parameter int unsigned IW    = INSTR_W,
    parameter int unsigned IDX_W = RF_IDX_W,
    parameter int unsigned A_LSB = SRC_A_LSB,
    parameter int unsigned B_LSB = SRC_B_LSB
) (
    input  logic [IW-1:0]    instr,
    output logic [IDX_W-1:0] src_a,
    output logic [IDX_W-1:0] src_b
);
    // Bits outside the two index fields are deliberately unused.
    logic unused_instr_bits;

    // Slice the fixed fields out of the instruction word.
    always_comb begin
        src_a = instr[A_LSB +: IDX_W];
        src_b = instr[B_LSB +: IDX_W];
        unused_instr_bits = ^instr;
    end
endmodule

// File: rtl/rf_storage.sv
// Register array with one synchronous write port. Entry 0 is a constant
// zero and has no flops. Synchronous active-low reset clears all entries.
// Assumes NUM_REGS is a power of two so every index value maps to an entry.
module rf_storage
    import regfile_pkg::*;
#(
    parameter int unsigned DATA_W   = RF_WIDTH,
    parameter int unsigned NUM_REGS = RF_REGS,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            // Entry 0 is tied to zero; writes to it have no target.
            assign regs_o[i] = '0;
        end else begin : g_flop
            logic sel;
            assign sel = wr_en && (wr_idx == IDX_W'(i));

            // Clear on reset, capture write data when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)   regs_o[i] <= '0;
                else if (sel) regs_o[i] <= wr_data;
            end

            AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IDX_W'(i)) |=> (regs_o[i] == $past(wr_data))); // R3
            AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(regs_o[i])); // R9
        end
    end
endmodule

// File: rtl/rf_read_port.sv
// One combinational read port. It forwards write-back data when the write
// targets the index being read, which gives write-before-read behaviour.
// Assumes regs_i[0] is constant zero; the bypass is suppressed for index 0.
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int unsigned DATA_W   = RF_WIDTH,
    parameter int unsigned NUM_REGS = RF_REGS,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] regs_i [NUM_REGS],
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic fwd_hit;

    // Select forwarded write data on an index match, else the stored entry.
    always_comb begin
        fwd_hit = wr_en && (wr_idx != '0) && (wr_idx == rd_idx);
        rd_data = fwd_hit ? wr_data : regs_i[rd_idx];
    end

    AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |-> (rd_data == '0)); // R2
    AST_SAME_CYCLE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && wr_idx == rd_idx) |-> (rd_data == wr_data)); // R4
endmodule

// File: rtl/regfile_bypass.sv
// Top of the register file: decodes the two source indices from the
// instruction, holds the array, and builds one read port per source.
// Assumes write-back drives wr_* for the full cycle before the edge.
module regfile_bypass
    import regfile_pkg::*;
#(
    parameter int unsigned DATA_W   = RF_WIDTH,
    parameter int unsigned NUM_REGS = RF_REGS,
    parameter int unsigned IW       = INSTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     dec_instr,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0]  src_idx  [NUM_RPORTS];
    logic [DATA_W-1:0] src_data [NUM_RPORTS];
    logic [DATA_W-1:0] regs     [NUM_REGS];

    rf_src_decode #(.IW(IW), .IDX_W(IDX_W), .A_LSB(SRC_A_LSB), .B_LSB(SRC_B_LSB)) dec_i (
        .instr (dec_instr),
        .src_a (src_idx[0]),
        .src_b (src_idx[1])
    );

    rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    for (genvar p = 0; p < NUM_RPORTS; p++) begin : g_port
        rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) port_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (src_idx[p]),
            .regs_i  (regs),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .rd_data (src_data[p])
        );
    end

    // Map the generic port array onto the named outputs.
    always_comb begin
        rd_data_a = src_data[0];
        rd_data_b = src_data[1];
    end
endmodule

// File: tb/regfile_bypass_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, full-array traffic and index-0 corner cases.
module regfile_bypass_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dec_instr = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;

    int tests_run = 0;
    int tests_failed = 0;

    always #2 clk = ~clk; // 250 MHz

    regfile_bypass dut_i (
        .clk(clk), .rst_n(rst_n), .dec_instr(dec_instr),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Junk in bits 31:26 and 15:0 exposes a wrong field position (R5).
    function automatic logic [31:0] mk_instr(input logic [4:0] a, input logic [4:0] b);
        return {6'h2B, a, b, 16'hC3A5};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive at the falling edge; outputs are combinational and are
    // sampled 1 ns later, before the next rising edge commits the write.
    task automatic drive(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                         input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd; dec_instr = mk_instr(ra, rb);
        #1;
    endtask

    typedef struct packed {
        logic        we;
        logic [4:0]  wi;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 5'd5,  32'h11111111, 5'd5,  5'd0,  32'h11111111, 32'h0,        8'd4}, // R4 fwd A, R2
        '{1'b1, 5'd6,  32'h22222222, 5'd5,  5'd6,  32'h11111111, 32'h22222222, 8'd4}, // R3 stored, R4 fwd B
        '{1'b0, 5'd5,  32'hDEADBEEF, 5'd5,  5'd6,  32'h11111111, 32'h22222222, 8'd7}, // R7 no fwd when disabled
        '{1'b1, 5'd0,  32'hFFFFFFFF, 5'd0,  5'd5,  32'h0,        32'h11111111, 8'd6}, // R6 no fwd to index 0
        '{1'b0, 5'd0,  32'h0,        5'd0,  5'd0,  32'h0,        32'h0,        8'd6}, // R6 index 0 still zero
        '{1'b1, 5'd31, 32'h80000001, 5'd31, 5'd31, 32'h80000001, 32'h80000001, 8'd4}, // R4 both ports
        '{1'b1, 5'd5,  32'h33333333, 5'd6,  5'd31, 32'h22222222, 32'h80000001, 8'd9}, // R9
        '{1'b0, 5'd0,  32'h0,        5'd5,  5'd6,  32'h33333333, 32'h22222222, 8'd3}, // R3 overwrite
        '{1'b1, 5'd1,  32'h0000FFFF, 5'd2,  5'd1,  32'h0,        32'h0000FFFF, 8'd5}, // R5 fields
        '{1'b0, 5'd0,  32'h0,        5'd1,  5'd31, 32'h0000FFFF, 32'h80000001, 8'd1}  // R1
    };

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400000;
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        apply_reset();

        // R8: every register reads zero after reset.
        for (int k = 0; k < 32; k++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(k), 5'(31 - k));
            check("R8 reset A", rd_data_a, 32'h0);
            check("R8 reset B", rd_data_b, 32'h0);
        end

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].we, VECS[v].wi, VECS[v].wd, VECS[v].ra, VECS[v].rb);
            check($sformatf("R%0d vec%0d A", VECS[v].req, v), rd_data_a, VECS[v].ea);
            check($sformatf("R%0d vec%0d B", VECS[v].req, v), rd_data_b, VECS[v].eb);
        end

        // R1/R9: fill all registers with distinct patterns, read every one back.
        for (int k = 0; k < 32; k++)
            drive(1'b1, 5'(k), 32'hA5000000 ^ (32'(k) * 32'h01010101), 5'd0, 5'd0);
        for (int k = 0; k < 32; k++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(k), 5'(31 - k));
            check("R1 fill A", rd_data_a, (k == 0) ? 32'h0 : 32'hA5000000 ^ (32'(k) * 32'h01010101));
            check("R1 fill B", rd_data_b, (k == 31) ? 32'h0 : 32'hA5000000 ^ (32'(31 - k) * 32'h01010101));
        end

        // R6: a write to index 0 must not disturb index 0 or any neighbour.
        drive(1'b1, 5'd0, 32'hCAFEF00D, 5'd0, 5'd1);
        drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd1);
        check("R6 idx0 after write", rd_data_a, 32'h0);
        check("R6 idx1 intact", rd_data_b, 32'hA5000000 ^ 32'h01010101);

        // R8: reset after traffic clears the whole file again.
        apply_reset();
        for (int k = 0; k < 32; k++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(k), 5'(k));
            check("R8 reclear A", rd_data_a, 32'h0);
            check("R8 reclear B", rd_data_b, 32'h0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule